// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one logic cell of a small programmable logic fabric. It takes 18 signals from a shared routing bus. It forms 24 programmable product terms from them. Twenty of those terms feed four OR sums. Each sum can be exclusive-ORed with its own dedicated product term. A narrow bypass lets an output use only the first four terms of its group and skip the XOR. Each of the four results can be presented combinationally or through an output register. Every output is also intended to be routed back onto the shared bus for other cells.

The function is set by a static configuration vector. That vector is copied into an active configuration register on a load strobe. Each output register picks one of three clock-enable lines, called ticks, or a hold setting. An active-high reset clears the registers and the active configuration. The reset acts asynchronously.

Top module: `lbk_logic_cell`

## Requirements
- R1: Term t (0..23) reads input i through the two configuration bits at [(t*18+i)*2 +: 2]. The code 00 ignores the input, 01 requires it to be 1, 10 requires it to be 0, and 11 forces the term to 0. The term is the AND of all its literals, so a term with no literals is 1.
- R2: Output k in 0..2 ORs terms 4k to 4k+3. Output 3 ORs terms 12 to 19.
- R3: Output k has a 5-bit control field at 864+5k. In that field, bit 0 selects registered mode, bit 1 enables the XOR, bit 2 enables the bypass, and bits 4:3 select the clock. With the XOR enabled, the sum is XORed with term 20+k. Otherwise it is XORed with 0.
- R4: With the bypass enabled, output k is the OR of the first four terms of its own group, and the XOR setting has no effect.
- R5: In combinational mode, output k follows the current bus value in the same cycle, and the tick lines have no effect on it.
- R6: In registered mode with clock select s in 0..2, the register loads the logic value at a rising clock edge where tick_in[s] is 1. It holds otherwise. The value appears on blk_out after that edge.
- R7: Clock select 3 makes the output register hold whatever the tick lines do.
- R8: Reset clears the output registers and the active configuration without waiting for a clock edge. After reset every output reads 1, because all terms are empty and combinational. Once registered mode is loaded with clock select 3, every output reads 0.
- R9: cfg_in reaches the active configuration only at a rising edge with cfg_load high. Changing cfg_in without the strobe leaves blk_out unchanged.
- R10: Each output's control field affects only that output, so the four outputs can mix modes freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Active-high reset, asynchronous |
| cfg_load | input | 1 | Strobe that copies cfg_in into the active configuration |
| cfg_in | input | 884 | Configuration vector: term literals, then per-output control fields |
| tick_in | input | 3 | Clock-enable lines selectable by each output register |
| bus_in | input | 18 | Routing-bus inputs to the product terms |
| blk_out | output | 4 | Cell outputs, also returned to the routing bus |

## Verification
Combinational results are due in the same cycle as the bus change. The bench changes inputs on the falling edge and samples 1 ns later. A registered result is due just after the first rising edge whose selected tick was high. The bench tracks this per output, updating its expected register copy only for the ticks it drove before that edge, and compares at the next falling edge. A new configuration counts from the rising edge that sees cfg_load. Ticks stay low during each load, so the register expectations carry across the load unchanged.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  // per-output control field width
  localparam int CTL_W = 5;

  // literal codes, two bits per input per term
  localparam logic [1:0] LIT_IGNORE = 2'b00;
  localparam logic [1:0] LIT_TRUE   = 2'b01;
  localparam logic [1:0] LIT_COMP   = 2'b10;
  localparam logic [1:0] LIT_KILL   = 2'b11;

  // clock select value that freezes an output register
  localparam logic [1:0] CLK_HOLD = 2'd3;

  typedef struct packed {
    logic [1:0] clk_sel;   // bits 4:3
    logic       fast_en;   // bit 2
    logic       xor_en;    // bit 1
    logic       reg_mode;  // bit 0
  } lbk_ctl_t;

  function automatic int main_terms(int n_out, int pt_small, int pt_last);
    return (n_out - 1) * pt_small + pt_last;
  endfunction

  function automatic int cfg_bits(int n_in, int n_out, int pt_small, int pt_last);
    return 2 * n_in * (main_terms(n_out, pt_small, pt_last) + n_out) + n_out * CTL_W;
  endfunction

endpackage

// File: rtl/lbk_and_array.sv
module lbk_and_array
  import lbk_pkg::*;
#(
  parameter int N_IN = 18,
  parameter int N_PT = 24
) (
  input  logic [N_PT*2*N_IN-1:0] term_cfg,
  input  logic [N_IN-1:0]        bus,
  output logic [N_PT-1:0]        pt
);

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_IN-1:0] hit;
    always_comb begin
      for (int i = 0; i < N_IN; i++) begin
        unique case (term_cfg[(t*N_IN+i)*2 +: 2])
          LIT_IGNORE: hit[i] = 1'b1;
          LIT_TRUE:   hit[i] = bus[i];
          LIT_COMP:   hit[i] = ~bus[i];
          LIT_KILL:   hit[i] = 1'b0;
        endcase
      end
    end
    assign pt[t] = &hit;
  end

endmodule

// File: rtl/lbk_sum_stage.sv
module lbk_sum_stage
  import lbk_pkg::*;
#(
  parameter int N_OUT    = 4,
  parameter int PT_SMALL = 4,
  parameter int PT_LAST  = 8,
  parameter int PT_FAST  = 4
) (
  input  logic [(N_OUT-1)*PT_SMALL+PT_LAST-1:0] pt_main,
  input  logic [N_OUT-1:0]                      pt_xor,
  input  lbk_ctl_t [N_OUT-1:0]                  ctl,
  output logic [N_OUT-1:0]                      sum_out
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_sum
    localparam int BASE = k * PT_SMALL;
    localparam int SIZE = (k == N_OUT - 1) ? PT_LAST : PT_SMALL;
    logic full_or;
    logic fast_or;
    logic xor_op;

    assign full_or = |pt_main[BASE +: SIZE];
    assign fast_or = |pt_main[BASE +: PT_FAST];
    assign xor_op  = ctl[k].xor_en & pt_xor[k];
    assign sum_out[k] = ctl[k].fast_en ? fast_or : (full_or ^ xor_op);
  end

endmodule

// File: rtl/lbk_out_cell.sv
module lbk_out_cell
  import lbk_pkg::*;
#(
  parameter int N_TICK = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  lbk_ctl_t          ctl,
  input  logic [N_TICK-1:0] tick,
  input  logic              d,
  output logic              dout
);

  logic en;
  logic q_r;

  always_comb begin
    en = 1'b0;
    for (int j = 0; j < N_TICK; j++) begin
      if (ctl.clk_sel == 2'(j)) en = tick[j];
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q_r <= 1'b0;
    else if (en) q_r <= d;
  end

  assign dout = ctl.reg_mode ? q_r : d;

  // R6: an enabled edge captures the logic value present before it
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    en |=> (q_r == $past(d)));

  // R7: hold select freezes the register
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl.clk_sel == CLK_HOLD) |=> $stable(q_r));

  // R8: register is clear at any edge seen during reset
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |-> (q_r == 1'b0));

endmodule

// File: rtl/lbk_logic_cell.sv
module lbk_logic_cell
  import lbk_pkg::*;
#(
  parameter int N_IN     = 18,
  parameter int N_OUT    = 4,
  parameter int PT_SMALL = 4,
  parameter int PT_LAST  = 8,
  parameter int PT_FAST  = 4,
  parameter int N_TICK   = 3
) (
  input  logic                                                clk,
  input  logic                                                rst,
  input  logic                                                cfg_load,
  input  logic [cfg_bits(N_IN,N_OUT,PT_SMALL,PT_LAST)-1:0]    cfg_in,
  input  logic [N_TICK-1:0]                                   tick_in,
  input  logic [N_IN-1:0]                                     bus_in,
  output logic [N_OUT-1:0]                                    blk_out
);

  localparam int TERM_W   = 2 * N_IN;
  localparam int N_MAIN   = main_terms(N_OUT, PT_SMALL, PT_LAST);
  localparam int N_PT     = N_MAIN + N_OUT;
  localparam int CTL_BASE = N_PT * TERM_W;
  localparam int CFG_W    = cfg_bits(N_IN, N_OUT, PT_SMALL, PT_LAST);

  logic [CFG_W-1:0]     cfg_q;
  logic [N_PT-1:0]      pt;
  lbk_ctl_t [N_OUT-1:0] ctl_v;
  logic [N_OUT-1:0]     sum;

  // active configuration, replaced only on the load strobe
  always_ff @(posedge clk or posedge rst) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_load) cfg_q <= cfg_in;
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_ctl
    assign ctl_v[k] = cfg_q[CTL_BASE + k*CTL_W +: CTL_W];
  end

  lbk_and_array #(
    .N_IN (N_IN),
    .N_PT (N_PT)
  ) u_and (
    .term_cfg (cfg_q[CTL_BASE-1:0]),
    .bus      (bus_in),
    .pt       (pt)
  );

  lbk_sum_stage #(
    .N_OUT    (N_OUT),
    .PT_SMALL (PT_SMALL),
    .PT_LAST  (PT_LAST),
    .PT_FAST  (PT_FAST)
  ) u_sum (
    .pt_main (pt[N_MAIN-1:0]),
    .pt_xor  (pt[N_MAIN +: N_OUT]),
    .ctl     (ctl_v),
    .sum_out (sum)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    lbk_out_cell #(
      .N_TICK (N_TICK)
    ) u_cell (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl_v[k]),
      .tick (tick_in),
      .d    (sum[k]),
      .dout (blk_out[k])
    );
  end

  // R9: without the strobe the active configuration does not move
  a_r9_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_q));

  // R9: the strobe copies the input vector
  a_r9_cfg_capture: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (cfg_q == $past(cfg_in)));

endmodule

// File: tb/test_lbk_logic_cell.sv
module test_lbk_logic_cell;

  localparam int N_IN  = 18;
  localparam int N_OUT = 4;
  localparam int PS    = 4;
  localparam int PL    = 8;
  localparam int PF    = 4;
  localparam int N_MAIN = (N_OUT-1)*PS + PL;
  localparam int N_PT  = N_MAIN + N_OUT;
  localparam int TW    = 2*N_IN;
  localparam int CW    = 5;
  localparam int CB    = N_PT*TW;
  localparam int CFG_W = CB + N_OUT*CW;

  logic clk = 1'b0;
  logic rst;
  logic cfg_load;
  logic [CFG_W-1:0] cfg_in;
  logic [CFG_W-1:0] act;
  logic [2:0] tick;
  logic [N_IN-1:0] bus;
  logic [N_OUT-1:0] blk_out;
  logic [N_OUT-1:0] eq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lbk_logic_cell i_lbk_logic_cell (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_in   (cfg_in),
    .tick_in  (tick),
    .bus_in   (bus),
    .blk_out  (blk_out)
  );

  function automatic logic [4:0] ctl(bit r, bit x, bit f, logic [1:0] s);
    return {s, f, x, r};
  endfunction

  // reference from R1..R4
  function automatic logic [3:0] model(logic [CFG_W-1:0] c, logic [N_IN-1:0] b);
    logic [N_PT-1:0] p;
    logic [3:0] r;
    for (int t = 0; t < N_PT; t++) begin
      p[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        logic [1:0] lit;
        lit = c[(t*N_IN+i)*2 +: 2];
        if (lit == 2'b11) p[t] = 1'b0;
        if (lit == 2'b01 && !b[i]) p[t] = 1'b0;
        if (lit == 2'b10 && b[i]) p[t] = 1'b0;
      end
    end
    for (int k = 0; k < N_OUT; k++) begin
      logic full, fast;
      logic [4:0] cf;
      int size;
      size = (k == N_OUT-1) ? PL : PS;
      full = 1'b0;
      fast = 1'b0;
      for (int j = 0; j < size; j++) full = full | p[k*PS+j];
      for (int j = 0; j < PF; j++) fast = fast | p[k*PS+j];
      cf = c[CB+k*CW +: CW];
      r[k] = cf[2] ? fast : (full ^ (cf[1] & p[N_MAIN+k]));
    end
    return r;
  endfunction

  function automatic logic [3:0] expect_out(logic [CFG_W-1:0] c, logic [N_IN-1:0] b, logic [3:0] q);
    logic [3:0] m, r;
    m = model(c, b);
    for (int k = 0; k < N_OUT; k++) r[k] = c[CB+k*CW] ? q[k] : m[k];
    return r;
  endfunction

  function automatic logic [CFG_W-1:0] rand_cfg(logic [4:0] c0, logic [4:0] c1,
                                                logic [4:0] c2, logic [4:0] c3);
    logic [CFG_W-1:0] c;
    c = '0;
    for (int t = 0; t < N_PT; t++) begin
      if ($urandom % 6 == 0) c[t*TW +: TW] = '1;
      else begin
        for (int i = 0; i < N_IN; i++) begin
          int r;
          r = $urandom % 16;
          c[(t*N_IN+i)*2 +: 2] = (r == 14) ? 2'b01 : (r == 15) ? 2'b10 : 2'b00;
        end
      end
    end
    c[CB +: 4*CW] = {c3, c2, c1, c0};
    return c;
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // load on the rising edge between two falling edges, ticks held low
  task automatic load_cfg(logic [CFG_W-1:0] c);
    @(negedge clk);
    cfg_in = c;
    cfg_load = 1'b1;
    tick = 3'b000;
    @(negedge clk);
    cfg_load = 1'b0;
    act = c;
  endtask

  task automatic comb_run(string tag, int n, bit use_ticks);
    for (int v = 0; v < n; v++) begin
      @(negedge clk);
      bus = N_IN'($urandom);
      tick = use_ticks ? 3'($urandom) : 3'b000;
      #1;
      chk(tag, blk_out, model(act, bus));
    end
  endtask

  task automatic reg_run(string tag, int n);
    for (int v = 0; v < n; v++) begin
      logic [3:0] m;
      @(negedge clk);
      #1;
      chk(tag, blk_out, expect_out(act, bus, eq));
      bus = N_IN'($urandom);
      tick = 3'($urandom);
      m = model(act, bus);
      for (int k = 0; k < N_OUT; k++) begin
        logic [1:0] s;
        s = act[CB+k*CW+3 +: 2];
        if (s != 2'd3 && tick[s]) eq[k] = m[k];
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CFG_W-1:0] c, c2;
    rst = 1'b1;
    cfg_load = 1'b0;
    cfg_in = '0;
    tick = 3'b000;
    bus = '0;
    act = '0;
    eq = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset state all ones", blk_out, 4'b1111);
    rst = 1'b0;

    // R1/R2 directed: empty term, kill code, last term of big group
    c = '0;
    for (int t = 0; t < N_PT; t++) c[t*TW +: TW] = '1;
    c[0*TW +: TW] = '0;
    c[4*TW +: TW] = '0;
    c[(4*N_IN+5)*2 +: 2] = 2'b11;
    c[19*TW +: TW] = '0;
    c[(19*N_IN+17)*2 +: 2] = 2'b01;
    c[CB +: 4*CW] = '0;
    load_cfg(c);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      bus = N_IN'($urandom);
      #1;
      chk("R1 R2 true literal last term", blk_out, {bus[17], 1'b0, 1'b0, 1'b1});
    end
    c[(19*N_IN+17)*2 +: 2] = 2'b10;
    load_cfg(c);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      bus = N_IN'($urandom);
      #1;
      chk("R1 R2 complement literal", blk_out, {~bus[17], 1'b0, 1'b0, 1'b1});
    end

    // R1 R2 R5: random arrays, combinational, ticks toggling
    for (int r = 0; r < 4; r++) begin
      load_cfg(rand_cfg(ctl(0,0,0,0), ctl(0,0,0,1), ctl(0,0,0,2), ctl(0,0,0,3)));
      comb_run("R2 R5 comb sums", 40, 1);
    end
    // R3 xor enabled on all outputs
    for (int r = 0; r < 4; r++) begin
      load_cfg(rand_cfg(ctl(0,1,0,0), ctl(0,1,0,0), ctl(0,1,0,0), ctl(0,1,0,0)));
      comb_run("R3 xor stage", 40, 0);
    end
    // R4 bypass with xor also set (xor must not act)
    for (int r = 0; r < 4; r++) begin
      load_cfg(rand_cfg(ctl(0,1,1,0), ctl(0,0,1,0), ctl(0,1,1,0), ctl(0,1,1,0)));
      comb_run("R4 fast bypass", 40, 0);
    end
    // R10 mixed per-output settings
    for (int r = 0; r < 4; r++) begin
      load_cfg(rand_cfg(ctl(0,1,0,0), ctl(0,0,1,0), ctl(0,0,0,0), ctl(0,1,1,0)));
      comb_run("R10 mixed comb settings", 40, 0);
    end

    // R9: cfg_in change without strobe has no effect
    c = rand_cfg(ctl(0,1,0,0), ctl(0,0,0,0), ctl(0,1,0,0), ctl(0,0,0,0));
    load_cfg(c);
    c2 = ~c;
    c2[CB +: 4*CW] = '0;
    @(negedge clk);
    cfg_in = c2;
    for (int v = 0; v < 20; v++) begin
      @(negedge clk);
      bus = N_IN'($urandom);
      #1;
      chk("R9 no strobe keeps config", blk_out, model(c, bus));
    end
    load_cfg(c2);
    comb_run("R9 strobe applies config", 20, 0);

    // R8: asynchronous reset mid-cycle
    @(negedge clk);
    #2;
    rst = 1'b1;
    #1;
    chk("R8 async reset clears config", blk_out, 4'b1111);
    @(negedge clk);
    rst = 1'b0;
    eq = '0;
    load_cfg(rand_cfg(ctl(1,0,0,3), ctl(1,1,0,3), ctl(1,0,1,3), ctl(1,1,0,3)));
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      tick = 3'b111;
      bus = N_IN'($urandom);
      #1;
      chk("R8 R7 cleared register held", blk_out, 4'b0000);
    end

    // R6 R7: each register on its own tick, out3 held
    load_cfg(rand_cfg(ctl(1,1,0,0), ctl(1,0,0,1), ctl(1,1,0,2), ctl(1,1,0,3)));
    reg_run("R6 R7 registered ticks", 80);
    // R5 R6 R10: mixed comb and registered, loaded mid-run
    load_cfg(rand_cfg(ctl(0,1,0,1), ctl(1,0,1,2), ctl(0,1,0,0), ctl(1,1,0,0)));
    reg_run("R10 mixed modes", 80);
    load_cfg(rand_cfg(ctl(1,0,0,2), ctl(1,1,0,0), ctl(1,0,1,1), ctl(0,0,0,3)));
    reg_run("R6 R9 reload keeps registers", 80);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule